// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and turns them into vectored interrupt requests. Each source has a request flag and an enable bit, and one global enable gates every source. An event always records its flag. The controller takes an interrupt only when that flag, its enable and the global enable are all set and the return-address stack has room. Pending sources compete in a fixed priority order. When the controller accepts a request, it sends the core a one-cycle take strobe and a vector address, and it drops the global enable so that handlers do not nest.

Most sources own a vector. A configurable group of sources shares one multi-function vector, which is driven by a summary of the group's enabled flags. Acceptance clears the flag of a dedicated source. Flags in the shared group stay set until software clears them. A return-from-interrupt notice restores the global enable. A wake output tells the power controller that a new flag was raised while the core sleeps or idles, whatever the state of that flag's enable.

There is no streaming data path. Every pin is a plain control or status signal, so the block uses no valid/ready handshake and has no back-pressure rules.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A high `evt_i[i]` in a cycle sets flag i at that clock edge, whatever the state of its enable bit or the global enable.
- R2: Acceptance happens in a cycle where some slot is requesting (its flag is set and enabled), `gie_o` is 1 and `stk_full_i` is 0. `take_o` is then high for exactly one cycle, in the cycle after the acceptance.
- R3: `vec_o` is loaded at acceptance with 0x04 + 4 × slot, where slot is the index of the winning dedicated source. For the shared group, slot is the lowest index in the group (0x18 for the default group, which is sources 5, 6 and 7).
- R4: Acceptance clears `gie_o`. No further acceptance occurs until `gie_o` is set again. Events that arrive meanwhile still set their flags.
- R5: No acceptance occurs while `stk_full_i` is 1. A pending request is taken in the cycle after `stk_full_i` falls.
- R6: Priority is fixed, and a lower slot index wins. The shared group competes at the slot of its lowest member.
- R7: Acceptance clears the winning flag of a dedicated source. Flags of shared-group sources are not changed by acceptance.
- R8: `reti_i` sets `gie_o` to 1. Within one cycle, acceptance takes precedence over `reti_i`, and `reti_i` takes precedence over a software write of the control register.
- R9: Register writes use `csr_addr`. Address 0 loads the flags, address 1 loads the enables, and address 2 loads `gie_o` from bit 0. An event in the same cycle as a flag write leaves that flag set.
- R10: While `sleep_i` is 1, `wake_o` is 1 if any flag has been set since `sleep_i` rose, enabled or not. A flag that was already set before sleep does not raise `wake_o`. `wake_o` is 0 whenever `sleep_i` is 0.
- R11: `grp_pend_o` is 1 exactly when some shared-group source has both its flag and its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N | Per-source event pulses |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select: 0 flags, 1 enables, 2 control |
| csr_wdata | input | N | Register write data |
| stk_full_i | input | 1 | Return-address stack is full |
| reti_i | input | 1 | Return-from-interrupt notice |
| sleep_i | input | 1 | Core is in sleep or idle mode |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| vec_o | output | VW | Vector address of the accepted interrupt |
| flags_o | output | N | Request flags |
| enables_o | output | N | Enable bits |
| gie_o | output | 1 | Global enable |
| grp_pend_o | output | 1 | Shared-group pending summary |
| wake_o | output | 1 | Wake request |

## Verification
Some properties are checked on every cycle by assertions:
- An event always leaves its flag set on the next cycle.
- A strobe never lasts two cycles.
- A strobe is never issued without a prior global enable and a stack with room, and `gie_o` is clear in the strobe cycle.
- A dedicated flag that is cleared by acceptance, with no competing event or write, reads zero afterwards.

The rest needs the directed scenarios:
- The exact vector values and the priority order between dedicated sources and the group.
- Shared flags staying set after acceptance.
- The precedence between a return and a control write.
- Wake behaving differently for flags raised before sleep and flags raised during it.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    CSR_FLAGS   = 2'd0,
    CSR_ENABLES = 2'd1,
    CSR_CTRL    = 2'd2
  } csr_sel_e;

  localparam int unsigned VEC_BASE = 4;
  localparam int unsigned VEC_STEP = 4;

  function automatic int unsigned slot_vector(input int unsigned slot);
    return VEC_BASE + VEC_STEP * slot;
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         flag_we,
  input  logic         en_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags,
  output logic [N-1:0] en
);

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (evt[i])     flags[i] <= 1'b1;
      else if (flag_we)    flags[i] <= wdata[i];
      else if (clr_mask[i]) flags[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en[i] <= 1'b0;
      else if (en_we)  en[i] <= wdata[i];
    end

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]); // R1

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !evt[i] && !flag_we) |=> !flags[i]); // R7
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned  N      = 8,
  parameter int unsigned  VW     = 8,
  parameter logic [N-1:0] SHARED = 8'hE0
) (
  input  logic [N-1:0]  flags,
  input  logic [N-1:0]  en,
  input  logic          accept,
  output logic          any_req,
  output logic [VW-1:0] win_vec,
  output logic [N-1:0]  clr_mask,
  output logic          grp_pend
);

  function automatic int unsigned lowest_member(input logic [N-1:0] m);
    int unsigned r = 0;
    for (int i = N - 1; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  localparam int unsigned GRP_SLOT = lowest_member(SHARED);

  logic [N-1:0] req;
  logic [N-1:0] slot_req;
  logic [N-1:0] win_oh;
  int unsigned  win_idx;

  assign req      = flags & en;
  assign grp_pend = |(req & SHARED);

  for (genvar i = 0; i < N; i++) begin : g_slot
    if (!SHARED[i]) begin : g_ded
      assign slot_req[i] = req[i];
    end else if (i == GRP_SLOT) begin : g_grp
      assign slot_req[i] = grp_pend;
    end else begin : g_hidden
      assign slot_req[i] = 1'b0;
    end
  end

  always_comb begin
    win_idx = 0;
    win_oh  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (slot_req[i]) win_idx = i;
    end
    if (|slot_req) win_oh[win_idx] = 1'b1;
  end

  assign any_req  = |slot_req;
  assign win_vec  = VW'(slot_vector(win_idx));
  assign clr_mask = accept ? (win_oh & ~SHARED) : '0;

endmodule

// File: rtl/irq_wake.sv
module irq_wake #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep,
  input  logic [N-1:0] flags,
  output logic         wake
);

  logic [N-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen <= '0;
    else if (!sleep) seen <= flags;
    else            seen <= seen & flags;
  end

  assign wake = sleep & |(flags & ~seen);

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned  N      = 8,
  parameter int unsigned  VW     = 8,
  parameter logic [N-1:0] SHARED = 8'hE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic          csr_we,
  input  logic [1:0]    csr_addr,
  input  logic [N-1:0]  csr_wdata,
  input  logic          stk_full_i,
  input  logic          reti_i,
  input  logic          sleep_i,
  output logic          take_o,
  output logic [VW-1:0] vec_o,
  output logic [N-1:0]  flags_o,
  output logic [N-1:0]  enables_o,
  output logic          gie_o,
  output logic          grp_pend_o,
  output logic          wake_o
);

  logic          gie_q;
  logic          any_req;
  logic          accept;
  logic [VW-1:0] win_vec;
  logic [N-1:0]  clr_mask;
  logic          flag_we;
  logic          en_we;
  logic          ctrl_we;

  assign flag_we = csr_we && (csr_addr == CSR_FLAGS);
  assign en_we   = csr_we && (csr_addr == CSR_ENABLES);
  assign ctrl_we = csr_we && (csr_addr == CSR_CTRL);

  irq_src_bank #(.N(N)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .flag_we  (flag_we),
    .en_we    (en_we),
    .wdata    (csr_wdata),
    .clr_mask (clr_mask),
    .flags    (flags_o),
    .en       (enables_o)
  );

  irq_arbiter #(.N(N), .VW(VW), .SHARED(SHARED)) u_arb (
    .flags    (flags_o),
    .en       (enables_o),
    .accept   (accept),
    .any_req  (any_req),
    .win_vec  (win_vec),
    .clr_mask (clr_mask),
    .grp_pend (grp_pend_o)
  );

  irq_wake #(.N(N)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .sleep (sleep_i),
    .flags (flags_o),
    .wake  (wake_o)
  );

  assign accept = gie_q && !stk_full_i && any_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie_q <= 1'b0;
    else if (accept)  gie_q <= 1'b0;
    else if (reti_i)  gie_q <= 1'b1;
    else if (ctrl_we) gie_q <= csr_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      take_o <= accept;
      if (accept) vec_o <= win_vec;
    end
  end

  assign gie_o = gie_q;

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o); // R2

  AST_TAKE_HAD_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(gie_q)); // R2

  AST_GIE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !gie_q); // R4

  AST_NO_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !$past(stk_full_i)); // R5

endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;

  localparam int N  = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          csr_we = 1'b0;
  logic [1:0]    csr_addr = '0;
  logic [N-1:0]  csr_wdata = '0;
  logic          stk_full_i = 1'b0;
  logic          reti_i = 1'b0;
  logic          sleep_i = 1'b0;
  logic          take_o;
  logic [VW-1:0] vec_o;
  logic [N-1:0]  flags_o;
  logic [N-1:0]  enables_o;
  logic          gie_o;
  logic          grp_pend_o;
  logic          wake_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl #(.N(N), .VW(VW), .SHARED(8'hE0)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .stk_full_i(stk_full_i),
    .reti_i(reti_i), .sleep_i(sleep_i), .take_o(take_o), .vec_o(vec_o),
    .flags_o(flags_o), .enables_o(enables_o), .gie_o(gie_o),
    .grp_pend_o(grp_pend_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    step();
    csr_we = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    evt_i = m;
    step();
    evt_i = '0;
  endtask

  task automatic do_reti();
    reti_i = 1'b1;
    step();
    reti_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 reset take", take_o, 0);
    check("R4 reset gie", gie_o, 0);
    check("R1 reset flags", flags_o, 0);
    check("R10 reset wake", wake_o, 0);
  endtask

  task automatic t_basic();
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    pulse(8'h01);
    check("R1 flag set", flags_o[0], 1);
    check("R2 no take yet", take_o, 0);
    step();
    check("R2 take strobe", take_o, 1);
    check("R3 vector slot0", vec_o, 8'h04);
    check("R4 gie cleared", gie_o, 0);
    check("R7 dedicated cleared", flags_o[0], 0);
    step();
    check("R2 strobe one cycle", take_o, 0);
  endtask

  task automatic t_disabled();
    wr(2'd2, 8'h01);
    pulse(8'h02);
    check("R1 flag while disabled", flags_o[1], 1);
    step(2);
    check("R2 no take when disabled", take_o, 0);
    wr(2'd1, 8'h02);
    step();
    check("R2 take after enable", take_o, 1);
    check("R3 vector slot1", vec_o, 8'h08);
  endtask

  task automatic t_gie();
    wr(2'd1, 8'h04);
    pulse(8'h04);
    step(3);
    check("R4 no take gie low", take_o, 0);
    check("R4 flag recorded", flags_o[2], 1);
    do_reti();
    check("R8 reti sets gie", gie_o, 1);
    step();
    check("R4 take after reti", take_o, 1);
    check("R3 vector slot2", vec_o, 8'h0C);
  endtask

  task automatic t_stack();
    wr(2'd1, 8'h08);
    stk_full_i = 1'b1;
    wr(2'd2, 8'h01);
    pulse(8'h08);
    step(4);
    check("R5 blocked by full stack", take_o, 0);
    stk_full_i = 1'b0;
    step();
    check("R5 take after room", take_o, 1);
    check("R3 vector slot3", vec_o, 8'h10);
  endtask

  task automatic t_prio();
    wr(2'd1, 8'hFF);
    pulse(8'h34);
    check("R11 group pending", grp_pend_o, 1);
    wr(2'd2, 8'h01);
    step();
    check("R6 first winner", vec_o, 8'h0C);
    check("R6 first take", take_o, 1);
    do_reti();
    step();
    check("R6 second winner", vec_o, 8'h14);
    do_reti();
    step();
    check("R6 group winner", vec_o, 8'h18);
    check("R7 shared flag kept", flags_o[5], 1);
    check("R11 still pending", grp_pend_o, 1);
    wr(2'd0, 8'h00);
    check("R11 group cleared", grp_pend_o, 0);
    wr(2'd1, 8'h80);
    pulse(8'h80);
    check("R11 member 7 pending", grp_pend_o, 1);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_csr();
    wr(2'd1, 8'h00);
    csr_we = 1'b1; csr_addr = 2'd0; csr_wdata = 8'h00; evt_i = 8'h02;
    step();
    csr_we = 1'b0; evt_i = '0;
    check("R9 event beats flag write", flags_o, 8'h02);
    wr(2'd0, 8'h41);
    check("R9 flag write", flags_o, 8'h41);
    wr(2'd1, 8'h00);
    check("R9 enable write", enables_o, 8'h00);
    reti_i = 1'b1; csr_we = 1'b1; csr_addr = 2'd2; csr_wdata = 8'h00;
    step();
    reti_i = 1'b0; csr_we = 1'b0;
    check("R8 reti beats ctrl write", gie_o, 1);
    wr(2'd2, 8'h00);
    check("R9 ctrl write clears gie", gie_o, 0);
  endtask

  task automatic t_wake();
    wr(2'd0, 8'h01);
    sleep_i = 1'b1;
    step(2);
    check("R10 old flag no wake", wake_o, 0);
    pulse(8'h80);
    check("R10 new flag wakes", wake_o, 1);
    sleep_i = 1'b0;
    #1;
    check("R10 awake no wake", wake_o, 0);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_disabled();
    t_gie();
    t_stack();
    t_prio();
    t_csr();
    t_wake();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule